// File: doc/BRIEF.md
# Reset and Watchdog Supervisor

This block is the digital core of a processor supervisor. It drives an active-low reset output, `resetN`. Reset is low whenever the supply-good input is low. After supply-good returns high, reset stays low for a fixed hold interval. At power-up the output starts low, so the first rise of supply-good behaves like any later recovery.

Once reset is released, a watchdog counter measures time since the last falling edge on the shared chip-select/kick input. Ordinary serial traffic therefore services the watchdog. If no falling edge arrives within the selected timeout, the block issues a reset pulse of the same hold length. The watchdog then starts counting again from zero.

The timeout is chosen by a 2-bit code held in a register that models a nonvolatile setting. Supply loss does not clear it. All intervals are counted in ticks of a free-running tick enable and are set by parameters, so a bench can shrink them. The analog comparator and the open-drain pad are outside this block.

Top module: `rstwd_supervisor`

## Requirements
- R1: Whenever `supplyGood` is low, `resetN` is low in the same cycle, with no register delay.
- R2: After `supplyGood` is sampled high following a low period, `resetN` stays low for the next HOLD_TICKS tick-enabled cycles and goes high after the last of them.
- R3: From time zero, before any clock edge with `supplyGood` high has completed a hold interval, `resetN` is low.
- R4: A high-to-low transition of `kickN` sampled by the clock restarts the watchdog count from zero. A low-to-high transition does not restart it.
- R5: While released, if `kickN` has no falling edge for the selected timeout (`kickN` held high or held low), `resetN` goes low for HOLD_TICKS ticks. It then goes high with the watchdog count restarted from zero.
- R6: The selection code maps as follows: 2'b00 gives a timeout of WD_LONG ticks, 2'b01 gives WD_MID ticks, 2'b10 gives WD_SHORT ticks, and 2'b11 disables the watchdog so that no watchdog reset ever occurs.
- R7: The selection register starts at DEFAULT_SEL. It loads `selCode` only on a cycle with `selWrite` high while `supplyGood` is high. It keeps its value through any period of `supplyGood` low.
- R8: The watchdog does not count while `supplyGood` is low or while a hold interval is running. After every release, the count starts from zero.
- R9: The hold and watchdog counters advance only on cycles with `tick` high. Cycles with `tick` low leave both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| tick | input | 1 | Time-base enable; one tick is one count unit |
| supplyGood | input | 1 | High when the supply is above its trip level |
| kickN | input | 1 | Shared chip-select / watchdog kick; a falling edge restarts the watchdog |
| selCode | input | 2 | Timeout selection code to store |
| selWrite | input | 1 | Store `selCode` into the persistent selection register |
| resetN | output | 1 | Active-low reset to the processor |

## Verification
Periodic kick pulses spaced well inside the timeout show that falling edges restart the count. Holding `kickN` high and then holding it low shows that the absence of a falling edge trips the watchdog, whatever level the pin holds. Each selection code is followed by an unkicked wait, so the three timeout lengths and the disabled setting can be told apart. A selection write attempted during supply loss, followed by recovery, separates a persistent register from one that is cleared or written during brownout. An irregular tick pattern separates tick-gated counting from counting on every clock.

// File: rtl/rstwd_pkg.sv
package rstwd_pkg;
  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_RUN  = 2'd2
  } supMode_t;

  typedef struct packed {
    logic holdClr;
    logic holdInc;
    logic wdClr;
    logic wdInc;
  } ctrlStrobe_t;

  localparam logic [1:0] SEL_OFF = 2'b11;
endpackage

// File: rtl/rstwd_datapath.sv
module rstwd_datapath
  import rstwd_pkg::*;
#(
  parameter int HOLD_TICKS  = 250,
  parameter int WD_LONG     = 1400,
  parameter int WD_MID      = 600,
  parameter int WD_SHORT    = 200,
  parameter logic [1:0] DEFAULT_SEL = 2'b00,
  parameter int WD_MAX      = 1400,
  parameter int CNT_W       = 11
) (
  input  logic        clk,
  input  logic        tick,
  input  logic        supplyGood,
  input  logic        kickN,
  input  logic [1:0]  selCode,
  input  logic        selWrite,
  input  ctrlStrobe_t str,
  output logic        holdDone,
  output logic        wdExpired,
  output logic        wdEnabled,
  output logic        kickFall
);
  logic [CNT_W-1:0] holdCnt = '0;
  logic [CNT_W-1:0] wdCnt   = '0;
  logic [CNT_W-1:0] wdLimit;
  logic [1:0]       selReg  = DEFAULT_SEL;
  logic             kickPrev = 1'b0;

  // persistent selection: no clear on supply loss, write blocked in brownout
  always_ff @(posedge clk) begin
    kickPrev <= kickN;
    if (supplyGood && selWrite) selReg <= selCode;
  end

  always_ff @(posedge clk) begin
    if (str.holdClr)      holdCnt <= '0;
    else if (str.holdInc) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (str.wdClr)      wdCnt <= '0;
    else if (str.wdInc) wdCnt <= wdCnt + 1'b1;
  end

  always_comb begin
    case (selReg)
      2'b00:   wdLimit = CNT_W'(WD_LONG);
      2'b01:   wdLimit = CNT_W'(WD_MID);
      2'b10:   wdLimit = CNT_W'(WD_SHORT);
      default: wdLimit = CNT_W'(WD_MAX);
    endcase
  end

  assign kickFall  = kickPrev && !kickN;
  assign wdEnabled = (selReg != SEL_OFF);
  assign holdDone  = (holdCnt == CNT_W'(HOLD_TICKS - 1));
  assign wdExpired = (wdCnt >= wdLimit - 1'b1);

  AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!supplyGood)
    kickFall |=> (wdCnt == '0)); // R4
  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!supplyGood)
    wdCnt < CNT_W'(WD_MAX)); // R6
  AST_SEL_KEPT: assert property (@(posedge clk)
    !supplyGood |=> $stable(selReg)); // R7
  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !supplyGood |=> (wdCnt == '0 && holdCnt == '0)); // R8
  AST_TICK_GATE: assert property (@(posedge clk)
    !tick |-> (!str.holdInc && !str.wdInc)); // R9
endmodule

// File: rtl/rstwd_control.sv
module rstwd_control
  import rstwd_pkg::*;
(
  input  logic        clk,
  input  logic        tick,
  input  logic        supplyGood,
  input  logic        holdDone,
  input  logic        wdExpired,
  input  logic        wdEnabled,
  input  logic        kickFall,
  output ctrlStrobe_t str,
  output logic        resetN
);
  supMode_t mode = MODE_LOW;
  supMode_t nextMode;

  always_comb begin
    str      = '0;
    nextMode = mode;
    if (!supplyGood) begin
      nextMode    = MODE_LOW;
      str.holdClr = 1'b1;
      str.wdClr   = 1'b1;
    end else begin
      case (mode)
        MODE_LOW: begin
          nextMode    = MODE_HOLD;
          str.holdClr = 1'b1;
          str.wdClr   = 1'b1;
        end
        MODE_HOLD: begin
          str.wdClr = 1'b1;
          if (tick) begin
            if (holdDone) begin
              nextMode    = MODE_RUN;
              str.holdClr = 1'b1;
            end else begin
              str.holdInc = 1'b1;
            end
          end
        end
        MODE_RUN: begin
          str.holdClr = 1'b1;
          if (!wdEnabled || kickFall) begin
            str.wdClr = 1'b1;
          end else if (tick) begin
            if (wdExpired) begin
              nextMode  = MODE_HOLD;
              str.wdClr = 1'b1;
            end else begin
              str.wdInc = 1'b1;
            end
          end
        end
        default: nextMode = MODE_LOW;
      endcase
    end
  end

  always_ff @(posedge clk) mode <= nextMode;

  assign resetN = supplyGood && (mode == MODE_RUN);

  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk)
    !supplyGood |-> !resetN); // R1
  AST_RISE_TO_HOLD: assert property (@(posedge clk) disable iff (!supplyGood)
    (mode == MODE_LOW) |=> (mode == MODE_HOLD)); // R2
  AST_RELEASE_FROM_HOLD: assert property (@(posedge clk) disable iff (!supplyGood)
    (mode == MODE_RUN) |-> ($past(mode) != MODE_LOW)); // R2
  AST_TIMEOUT_TO_HOLD: assert property (@(posedge clk) disable iff (!supplyGood)
    (mode == MODE_RUN && tick && wdEnabled && !kickFall && wdExpired)
      |=> (mode == MODE_HOLD && !resetN)); // R5
endmodule

// File: rtl/rstwd_supervisor.sv
module rstwd_supervisor #(
  parameter int HOLD_TICKS  = 250,
  parameter int WD_LONG     = 1400,
  parameter int WD_MID      = 600,
  parameter int WD_SHORT    = 200,
  parameter logic [1:0] DEFAULT_SEL = 2'b00
) (
  input  logic       clk,
  input  logic       tick,
  input  logic       supplyGood,
  input  logic       kickN,
  input  logic [1:0] selCode,
  input  logic       selWrite,
  output logic       resetN
);
  import rstwd_pkg::*;

  localparam int WD_MAX_A = (WD_LONG > WD_MID) ? WD_LONG : WD_MID;
  localparam int WD_MAX   = (WD_MAX_A > WD_SHORT) ? WD_MAX_A : WD_SHORT;
  localparam int CNT_MAX  = (WD_MAX > HOLD_TICKS) ? WD_MAX : HOLD_TICKS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  ctrlStrobe_t str;
  logic holdDone, wdExpired, wdEnabled, kickFall;

  rstwd_datapath #(
    .HOLD_TICKS(HOLD_TICKS), .WD_LONG(WD_LONG), .WD_MID(WD_MID),
    .WD_SHORT(WD_SHORT), .DEFAULT_SEL(DEFAULT_SEL), .WD_MAX(WD_MAX),
    .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .tick(tick), .supplyGood(supplyGood), .kickN(kickN),
    .selCode(selCode), .selWrite(selWrite), .str(str),
    .holdDone(holdDone), .wdExpired(wdExpired), .wdEnabled(wdEnabled),
    .kickFall(kickFall)
  );

  rstwd_control uCtrl (
    .clk(clk), .tick(tick), .supplyGood(supplyGood), .holdDone(holdDone),
    .wdExpired(wdExpired), .wdEnabled(wdEnabled), .kickFall(kickFall),
    .str(str), .resetN(resetN)
  );
endmodule

// File: tb/tb_rstwd_supervisor.sv
module tb_rstwd_supervisor;
  localparam int HOLD  = 6;
  localparam int LONG  = 20;
  localparam int MID   = 12;
  localparam int SHORT = 8;

  logic clk = 1'b0;
  logic tick = 1'b1;
  logic supplyGood = 1'b0;
  logic kickN = 1'b1;
  logic [1:0] selCode = 2'b00;
  logic selWrite = 1'b0;
  logic resetN;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string curReq = "R3";

  // reference model state
  int mMode = 0;   // 0 supply low, 1 holding, 2 released
  int mHold = 0;
  int mAge = 0;
  int mSel = 0;
  bit mPrev = 1'b0;

  always #2 clk = ~clk;

  rstwd_supervisor #(
    .HOLD_TICKS(HOLD), .WD_LONG(LONG), .WD_MID(MID), .WD_SHORT(SHORT),
    .DEFAULT_SEL(2'b00)
  ) dut (
    .clk(clk), .tick(tick), .supplyGood(supplyGood), .kickN(kickN),
    .selCode(selCode), .selWrite(selWrite), .resetN(resetN)
  );

  function automatic int limitOf(int s);
    if (s == 0) return LONG;
    if (s == 1) return MID;
    return SHORT;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: resetN actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit kf;
    cycles++;
    kf = mPrev && !kickN;
    mPrev = kickN;
    if (!supplyGood) begin
      mMode = 0; mHold = 0; mAge = 0;
    end else if (mMode == 0) begin
      mMode = 1; mHold = 0; mAge = 0;
    end else if (mMode == 1) begin
      if (tick) begin
        if (mHold == HOLD - 1) begin mMode = 2; mHold = 0; end
        else mHold++;
      end
    end else begin
      if (mSel == 3 || kf) mAge = 0;
      else if (tick) begin
        if (mAge >= limitOf(mSel) - 1) begin mMode = 1; mHold = 0; mAge = 0; end
        else mAge++;
      end
    end
    if (supplyGood && selWrite) mSel = int'(selCode);
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d expected below %0d cycles", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
    end
  end

  // compare against the model once per clock, away from the active edge
  always @(negedge clk) begin
    int expv;
    expv = (supplyGood && mMode == 2) ? 1 : 0;
    check(int'(resetN) == expv, curReq, int'(resetN), expv);
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kickPulse();
    @(negedge clk) kickN = 1'b0;
    @(negedge clk) kickN = 1'b1;
  endtask

  task automatic writeSel(logic [1:0] c);
    @(negedge clk) begin selCode = c; selWrite = 1'b1; end
    @(negedge clk) selWrite = 1'b0;
  endtask

  initial begin
    #1;
    check(resetN == 1'b0, "R3", int'(resetN), 0);   // R3 power-up state
    curReq = "R1";
    waitCycles(5);

    curReq = "R2";
    @(negedge clk) supplyGood = 1'b1;
    waitCycles(HOLD);
    #1 check(resetN == 1'b0, "R2", int'(resetN), 0); // still holding
    waitCycles(3);
    check(resetN == 1'b1, "R2", int'(resetN), 1);

    curReq = "R4";   // periodic kicks inside the long timeout
    for (int i = 0; i < 8; i++) begin
      kickPulse();
      waitCycles(8);
    end
    check(resetN == 1'b1, "R4", int'(resetN), 1);

    curReq = "R5";   // kick stuck high, then stuck low
    waitCycles(40);
    @(negedge clk) kickN = 1'b0;
    waitCycles(40);
    @(negedge clk) kickN = 1'b1;

    curReq = "R6";
    writeSel(2'b10);
    kickPulse();
    waitCycles(20);
    writeSel(2'b01);
    kickPulse();
    waitCycles(30);
    writeSel(2'b11);
    kickPulse();
    waitCycles(HOLD + 2);
    waitCycles(60);
    check(resetN == 1'b1, "R6", int'(resetN), 1);    // disabled: never trips

    curReq = "R7";   // write during brownout is dropped, setting persists
    @(negedge clk) supplyGood = 1'b0;
    writeSel(2'b00);
    waitCycles(3);
    @(negedge clk) supplyGood = 1'b1;
    waitCycles(HOLD + 60);
    check(resetN == 1'b1, "R7", int'(resetN), 1);

    curReq = "R9";   // irregular tick enable
    writeSel(2'b01);
    kickPulse();
    for (int i = 0; i < 80; i++) begin
      @(negedge clk) tick = ((i % 3) != 0);
    end
    @(negedge clk) tick = 1'b1;

    curReq = "R8";   // brownout with stuck kick, fresh count after release
    @(negedge clk) begin supplyGood = 1'b0; kickN = 1'b0; end
    waitCycles(4);
    @(negedge clk) supplyGood = 1'b1;
    waitCycles(HOLD + MID);
    waitCycles(30);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule